// File: doc/BRIEF.md
# Even-Ratio Clock Divider with Glitch-Free Restart

This block takes one input clock and produces a slower clock whose period is an even number of input cycles, from 2 to 16, chosen by a 3-bit select. High and low phases are always equal in length, so the output has an exact 50% duty cycle at every ratio. A counter runs to half the period length, and the output flips each time the counter wraps.

A synchronous restart input parks the output low without ever cutting a pulse short. If the output is high when the restart arrives, the high phase runs to its full length first. A new ratio is only picked up at the end of a full output period, or during a restart, so each period in progress keeps its shape. Because both phases have the same length, the output can clock registers that capture on both edges. This gives the full data rate while the clock net toggles at half the rate or less.

Top module: `even_clk_div`

## Requirements
- R1: While `rst` is high, `clk_out` is 0 at every edge. The select value present during reset sets the first ratio after reset.
- R2: The ratio is 2×(`ratio_sel`+1) input cycles: select 0 gives 2, select 7 gives 16. Each high phase of `clk_out` lasts `ratio_sel`+1 input cycles.
- R3: Each low phase lasts the same `ratio_sel`+1 input cycles, so the duty cycle is 50% at all eight ratios.
- R4: A change on `ratio_sel` is taken only at the input edge where `clk_out` falls. The rest of the period in progress keeps the old ratio, and the next low and high phases both use the new one.
- R5: If `div_rst` is raised while `clk_out` is high, the high phase still completes its full length before `clk_out` falls. No shortened high pulse is produced.
- R6: While `div_rst` is high and `clk_out` is low, `clk_out` stays low and the divider is held at the start of a low phase.
- R7: After `div_rst` (or `rst`) is released, the first low phase lasts `ratio_sel`+1 input cycles. Its length comes from the select value on the last restart edge.
- R8: `clk_out` changes level only on an edge where the internal half-period counter is at its terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset, forces the output low at once |
| div_rst | input | 1 | Synchronous restart; holds the output low without truncating a high phase |
| ratio_sel | input | 3 | Ratio select; the ratio is 2×(value+1) |
| clk_out | output | 1 | Divided clock with 50% duty cycle |

## Verification
The output flop sits one register after the counter compare, so a level change is seen on the input edge where the counter reaches `ratio_sel`. The bench samples on the falling input edge, after that register has settled. The bench counts identical consecutive samples and checks each completed phase length against `ratio_sel`+1. The select value used is the one that stood on the edge where the output last fell, or on the last restart edge. Restart inputs take effect on the next rising edge. The bench therefore tracks which sampled edge saw a restart, and checks both the parked-low hold and the length of the first low phase from that edge.

// File: rtl/even_div_pkg.sv
package even_div_pkg;

    localparam int unsigned DEF_SEL_W = 3;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // control produced by the output stage each cycle
    typedef struct packed {
        logic wrap;   // counter at terminal this cycle
        logic park;   // restart request honoured (output low)
        logic load;   // take a new ratio into the hold register
    } div_ctl_t;

    function automatic int unsigned ratio_of(input int unsigned sel);
        return 2 * (sel + 1);
    endfunction

endpackage

// File: rtl/div_ratio_hold.sv
module div_ratio_hold #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (load) sel_q <= sel_in;
    end
endmodule

// File: rtl/div_phase_count.sv
module div_phase_count #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [SEL_W-1:0] term_val,
    output logic             wrap
);
    localparam int unsigned CNT_W = SEL_W;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign wrap = (cnt == term_val);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= term_val);
endmodule

// File: rtl/div_out_stage.sv
module div_out_stage
    import even_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     div_rst,
    input  logic     wrap,
    output div_ctl_t ctl,
    output logic     clk_out
);
    phase_e ph;
    logic   park;

    assign park     = div_rst && (ph == PH_LOW);
    assign ctl.wrap = wrap;
    assign ctl.park = park;
    assign ctl.load = rst || park || (wrap && (ph == PH_HIGH));

    always_ff @(posedge clk) begin
        if (rst || park)  ph <= PH_LOW;
        else if (wrap)    ph <= (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
    end

    assign clk_out = (ph == PH_HIGH);

    // R6
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        (div_rst && !clk_out) |=> !clk_out);

    // R5
    high_full_chk: assert property (@(posedge clk) disable iff (rst)
        (div_rst && clk_out && !wrap) |=> clk_out);

    // R8
    toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_out != $past(clk_out)) |-> $past(wrap));
endmodule

// File: rtl/even_clk_div.sv
module even_clk_div
    import even_div_pkg::*;
#(
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic             div_rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_out
);
    logic [SEL_W-1:0] active_sel;
    logic             wrap;
    div_ctl_t         ctl;

    div_ratio_hold #(.SEL_W(SEL_W)) u_hold (
        .clk    (clk_in),
        .load   (ctl.load),
        .sel_in (ratio_sel),
        .sel_q  (active_sel)
    );

    div_phase_count #(.SEL_W(SEL_W)) u_cnt (
        .clk      (clk_in),
        .rst      (rst),
        .clear    (ctl.park || ctl.wrap),
        .term_val (active_sel),
        .wrap     (wrap)
    );

    div_out_stage u_out (
        .clk     (clk_in),
        .rst     (rst),
        .div_rst (div_rst),
        .wrap    (wrap),
        .ctl     (ctl),
        .clk_out (clk_out)
    );

    // R4
    sel_change_chk: assert property (@(posedge clk_in) disable iff (rst)
        (active_sel != $past(active_sel)) |-> ($fell(clk_out) || $past(div_rst)));
endmodule

// File: tb/tb_even_clk_div.sv
`timescale 1ns/1ps
module tb_even_clk_div;
    logic       clk = 1'b0;
    logic       rst_v = 1'b1;
    logic       drst_v = 1'b0;
    logic [2:0] sel_v = 3'd0;
    logic       clk_out;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // monitor state
    bit held = 1;
    bit lvl = 0;
    int run = 0;
    int exp_len = 1;
    int pend_r4 = 0;
    bit after_rel = 0;

    always #2.5 clk = ~clk;

    even_clk_div dut (
        .clk_in    (clk),
        .rst       (rst_v),
        .div_rst   (drst_v),
        .ratio_sel (sel_v),
        .clk_out   (clk_out)
    );

    function automatic int half_len(input logic [2:0] s);
        return (2 * (int'(s) + 1)) / 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic restart_state();
        held = 1; lvl = 0; run = 1; exp_len = half_len(sel_v); after_rel = 1;
    endtask

    // one falling edge: sample, evaluate against the values applied at the last rising edge
    task automatic step();
        logic o;
        string tag;
        @(negedge clk);
        o = clk_out;
        if (rst_v) begin
            chk(o == 1'b0, "R1 low in reset", int'(o), 0);
            restart_state();
            return;
        end
        if (drst_v) begin
            if (held) begin
                chk(o == 1'b0, "R6 parked low", int'(o), 0);
                restart_state();
            end else if (lvl == 1'b1) begin
                if (o == 1'b1) run++;
                else begin
                    chk(run == exp_len, "R5 high kept full length", run, exp_len);
                    restart_state();
                end
            end else begin
                chk(o == 1'b0, "R6 no rise while parked", int'(o), 0);
                restart_state();
            end
            return;
        end
        held = 0;
        if (o == lvl) begin
            run++;
            if (run > 16) begin
                chk(0, "R8 phase never ended", run, exp_len);
                run = 1;
            end
        end else begin
            if (pend_r4 > 0)      tag = "R4 ratio switch";
            else if (after_rel)   tag = "R7 first low after restart";
            else if (lvl)         tag = "R2 high length";
            else                  tag = "R3 low length";
            chk(run == exp_len, tag, run, exp_len);
            if (pend_r4 > 0) pend_r4--;
            after_rel = 0;
            if (lvl == 1'b1) exp_len = half_len(sel_v);
            lvl = o;
            run = 1;
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic restart(input logic [2:0] s, input int hold);
        sel_v = s;
        drst_v = 1'b1;
        steps(hold);
        drst_v = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state and first ratio
        sel_v = 3'd2;
        steps(4);
        rst_v = 1'b0;
        steps(20);

        // R2 R3 R7: every select after a restart
        for (int s = 0; s < 8; s++) begin
            restart(3'(s), 2);
            steps(6 * (s + 1) + 2);
        end

        // R4: switch ratio in mid period without restart
        restart(3'd1, 2);
        steps(5);
        sel_v = 3'd6; pend_r4 = 3;
        steps(60);
        sel_v = 3'd0; pend_r4 = 3;
        steps(20);

        // R5: restart raised while output is high
        restart(3'd7, 2);
        while (clk_out !== 1'b1) step();
        step();
        drst_v = 1'b1;
        steps(30);
        drst_v = 1'b0;
        steps(40);

        // random mix
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom % 6;
            if (r == 0) begin
                restart(3'($urandom % 8), 1 + ($urandom % 5));
            end else begin
                sel_v = 3'($urandom % 8);
                pend_r4 = 2;
            end
            steps(1 + ($urandom % 40));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule